// File: doc/BRIEF.md
# Dual External Interrupt Controller

This block adds two more active-low external interrupt inputs to an 8-bit microcontroller. Both inputs are controlled from a single 8-bit special-function register. Software can write that register as a whole byte, or one bit at a time through its bit addresses. Each pin is synchronised to the clock. Each pin can then be set to detect a falling edge or a low level. The result is kept in a pending flag for each source. The enable bit for a source gates its flag into a request. The priority bit for a source sets that request's level.

The CPU names the source it is servicing through a service-acknowledge input. In edge mode, that acknowledge clears the flag. In level mode, the flag simply tracks the pin, so the acknowledge does nothing. The block also chooses which pending request the CPU should take next. A high-level request beats a low-level one. Within one level, the first source (INT2) beats the second (INT3).

Top module: `xint_ctrl`

## Requirements
- R1: After reset the control register reads 0x00 at address 0xC0, and every request and select output is low. A read at any address other than 0xC0 returns 0x00.
- R2: A byte write to address 0xC0 loads the register. The layout from bit 7 down to bit 0 is PX3, EX3, IE3, IT3, PX2, EX2, IE2, IT2. A byte write to any other address leaves the register unchanged.
- R3: A bit write to address 0xC0+k, where k is 0 to 7, changes only bit k of the register.
- R4: With ITn=1 (edge mode), a high-to-low transition on pin n sets IEn on the third rising clock edge after the pin falls. A pin that stays low does not set the flag again.
- R5: In edge mode, an acknowledge of source n clears IEn. An acknowledge of the other source leaves IEn unchanged. The acknowledge source code is 0 for INT2 and 1 for INT3.
- R6: With ITn=0 (level mode), IEn follows the inverted synchronised pin, and an acknowledge has no effect on it.
- R7: irq_req bit n (bit 0 for INT2, bit 1 for INT3) equals IEn AND EXn.
- R8: irq_hi bit n equals PXn, where 1 means the high level.
- R9: sel_valid is high when any irq_req bit is high. sel_src names the winner: a high-level request first, then INT2 ahead of INT3 within the same level.
- R10: If a software write clears IEn in the same cycle that hardware detects an edge on source n, the flag ends up set.
- R11: In edge mode, software can set or clear IEn directly through a byte write or a bit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_wr_en | input | 1 | Byte write strobe |
| sfr_wr_addr | input | 8 | Byte write address |
| sfr_wr_data | input | 8 | Byte write data |
| bit_wr_en | input | 1 | Bit write strobe |
| bit_wr_addr | input | 8 | Bit address |
| bit_wr_val | input | 1 | Bit write value |
| sfr_rd_addr | input | 8 | Read address |
| sfr_rd_data | output | 8 | Read data, combinational |
| int_pin_n | input | 2 | Active-low interrupt pins, bit 0 = INT2 |
| ack_valid | input | 1 | Service acknowledge strobe |
| ack_src | input | 1 | Acknowledged source, 0 = INT2 |
| irq_req | output | 2 | Enabled pending requests |
| irq_hi | output | 2 | Priority level for each source |
| sel_valid | output | 1 | Some request is pending |
| sel_src | output | 1 | Winning source |

## Verification
The bench drives random register bytes and random single-bit writes with both sources in edge mode. These patterns cover every mix of enable, flag and priority, so they show whether the gating, the priority levels and the polling order within a level are correct. Directed pin sequences then test edge mode against level mode. They measure the three-edge set latency, show that a held-low pin does not retrigger, and show that an acknowledge aimed at the wrong source changes nothing. A final case puts a software clear and a detected edge in the same cycle to show that the hardware set wins.

// File: rtl/xint_pkg.sv
package xint_pkg;
   localparam int FLD_W  = 4;
   localparam int FLD_IT = 0;
   localparam int FLD_IE = 1;
   localparam int FLD_EX = 2;
   localparam int FLD_PX = 3;

   typedef struct packed {
      logic px;
      logic ex;
      logic ie;
      logic it;
   } xint_field_t;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("xint_sync needs at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xint_source.sv
module xint_source (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s_i,
   input  logic mode_edge_i,
   input  logic sw_we_i,
   input  logic sw_val_i,
   input  logic ack_i,
   output logic flag_o
);
   logic prev_q;
   logic fall;
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= pin_s_i;
   end

   assign fall = prev_q & ~pin_s_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flag_q <= 1'b0;
      else if (!mode_edge_i) flag_q <= ~pin_s_i;
      else if (fall)         flag_q <= 1'b1;
      else if (sw_we_i)      flag_q <= sw_val_i;
      else if (ack_i)        flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_edge_i && fall) |=> flag_q); // R4
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_edge_i && ack_i && !fall && !sw_we_i) |=> !flag_q); // R5
   AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_edge_i) |=> (flag_q == !$past(pin_s_i))); // R6
   AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_edge_i && fall && sw_we_i && !sw_val_i) |=> flag_q); // R10
endmodule

// File: rtl/xint_arb.sv
module xint_arb #(
   parameter int NUM_SRC = 2,
   localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] hi_i,
   output logic [NUM_SRC-1:0] grant_o,
   output logic               valid_o,
   output logic [SRC_W-1:0]   idx_o
);
   logic [NUM_SRC-1:0] hi_req;
   logic [NUM_SRC-1:0] pool;

   assign hi_req  = req_i & hi_i;
   assign pool    = (|hi_req) ? hi_req : req_i;
   assign valid_o = |req_i;

   always_comb begin
      logic found;
      found   = 1'b0;
      grant_o = '0;
      idx_o   = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (pool[i] && !found) begin
            found      = 1'b1;
            grant_o[i] = 1'b1;
            idx_o      = SRC_W'(i);
         end
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o) && (valid_o == (|grant_o))); // R9
   AST_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (|(req_i & hi_i)) |-> (|(grant_o & hi_i))); // R9
   AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant_o) |-> (|(grant_o & req_i))); // R9
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl #(
   parameter int         NUM_SRC     = 2,
   parameter int         SYNC_STAGES = 2,
   parameter int         ADDR_W      = 8,
   parameter logic [7:0] SFR_ADDR    = 8'hC0,
   localparam int        REG_W       = NUM_SRC * xint_pkg::FLD_W,
   localparam int        SRC_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sfr_wr_en,
   input  logic [ADDR_W-1:0]  sfr_wr_addr,
   input  logic [REG_W-1:0]   sfr_wr_data,
   input  logic               bit_wr_en,
   input  logic [ADDR_W-1:0]  bit_wr_addr,
   input  logic               bit_wr_val,
   input  logic [ADDR_W-1:0]  sfr_rd_addr,
   output logic [REG_W-1:0]   sfr_rd_data,
   input  logic [NUM_SRC-1:0] int_pin_n,
   input  logic               ack_valid,
   input  logic [SRC_W-1:0]   ack_src,
   output logic [NUM_SRC-1:0] irq_req,
   output logic [NUM_SRC-1:0] irq_hi,
   output logic               sel_valid,
   output logic [SRC_W-1:0]   sel_src
);
   import xint_pkg::*;

   localparam int BIT_SEL_W = $clog2(REG_W);

   if (REG_W != 8) begin : g_bad_width
      $error("control register must be 8 bits wide");
   end
   if (SFR_ADDR[BIT_SEL_W-1:0] != '0) begin : g_bad_addr
      $error("register address must be aligned to its bit count");
   end

   logic               byte_hit;
   logic               bit_hit;
   logic [REG_W-1:0]   wmask;
   logic [REG_W-1:0]   wval;
   logic [REG_W-1:0]   reg_view;
   logic [NUM_SRC-1:0] it_q, ex_q, px_q, flag;
   logic [NUM_SRC-1:0] grant;

   assign byte_hit = sfr_wr_en && (sfr_wr_addr == ADDR_W'(SFR_ADDR));
   assign bit_hit  = bit_wr_en &&
                     (bit_wr_addr[ADDR_W-1:BIT_SEL_W] == SFR_ADDR[ADDR_W-1:BIT_SEL_W]);

   always_comb begin
      wmask = '0;
      wval  = '0;
      if (byte_hit) begin
         wmask = '1;
         wval  = sfr_wr_data;
      end else if (bit_hit) begin
         wmask[bit_wr_addr[BIT_SEL_W-1:0]] = 1'b1;
         wval[bit_wr_addr[BIT_SEL_W-1:0]]  = bit_wr_val;
      end
   end

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      localparam int B = n * FLD_W;
      logic        pin_s;
      xint_field_t fld;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            it_q[n] <= 1'b0;
            ex_q[n] <= 1'b0;
            px_q[n] <= 1'b0;
         end else begin
            if (wmask[B+FLD_IT]) it_q[n] <= wval[B+FLD_IT];
            if (wmask[B+FLD_EX]) ex_q[n] <= wval[B+FLD_EX];
            if (wmask[B+FLD_PX]) px_q[n] <= wval[B+FLD_PX];
         end
      end

      xint_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (int_pin_n[n]),
         .q_o   (pin_s)
      );

      xint_source u_src (
         .clk         (clk),
         .rst_n       (rst_n),
         .pin_s_i     (pin_s),
         .mode_edge_i (it_q[n]),
         .sw_we_i     (wmask[B+FLD_IE]),
         .sw_val_i    (wval[B+FLD_IE]),
         .ack_i       (ack_valid && (ack_src == SRC_W'(n))),
         .flag_o      (flag[n])
      );

      assign fld.px = px_q[n];
      assign fld.ex = ex_q[n];
      assign fld.ie = flag[n];
      assign fld.it = it_q[n];
      assign reg_view[B +: FLD_W] = fld;
   end

   assign sfr_rd_data = (sfr_rd_addr == ADDR_W'(SFR_ADDR)) ? reg_view : '0;
   assign irq_req     = flag & ex_q;
   assign irq_hi      = px_q;

   xint_arb #(.NUM_SRC(NUM_SRC)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (irq_req),
      .hi_i    (irq_hi),
      .grant_o (grant),
      .valid_o (sel_valid),
      .idx_o   (sel_src)
   );

   AST_BYTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      byte_hit |=> ((ex_q == $past({sfr_wr_data[6], sfr_wr_data[2]})) &&
                    (px_q == $past({sfr_wr_data[7], sfr_wr_data[3]})))); // R2
   AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_hit && !bit_hit) |=> ($stable(ex_q) && $stable(px_q) && $stable(it_q))); // R3
endmodule

// File: tb/xint_ctrl_bench.sv
`timescale 1ns/1ps
module xint_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sfr_wr_en = 1'b0;
   logic [7:0] sfr_wr_addr = 8'h00;
   logic [7:0] sfr_wr_data = 8'h00;
   logic       bit_wr_en = 1'b0;
   logic [7:0] bit_wr_addr = 8'h00;
   logic       bit_wr_val = 1'b0;
   logic [7:0] sfr_rd_addr = 8'hC0;
   logic [7:0] sfr_rd_data;
   logic [1:0] int_pin_n = 2'b11;
   logic       ack_valid = 1'b0;
   logic [0:0] ack_src = 1'b0;
   logic [1:0] irq_req, irq_hi;
   logic       sel_valid;
   logic [0:0] sel_src;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   xint_ctrl u_xint_ctrl (
      .clk(clk), .rst_n(rst_n),
      .sfr_wr_en(sfr_wr_en), .sfr_wr_addr(sfr_wr_addr), .sfr_wr_data(sfr_wr_data),
      .bit_wr_en(bit_wr_en), .bit_wr_addr(bit_wr_addr), .bit_wr_val(bit_wr_val),
      .sfr_rd_addr(sfr_rd_addr), .sfr_rd_data(sfr_rd_data),
      .int_pin_n(int_pin_n), .ack_valid(ack_valid), .ack_src(ack_src),
      .irq_req(irq_req), .irq_hi(irq_hi), .sel_valid(sel_valid), .sel_src(sel_src)
   );

   function automatic logic [1:0] exp_req(input logic [7:0] m);
      return {m[6] & m[5], m[2] & m[1]};
   endfunction

   function automatic logic [1:0] exp_sel(input logic [7:0] m);
      logic [1:0] r, h;
      r = exp_req(m);
      h = r & {m[7], m[3]};
      if (h[0])      return 2'b10;
      else if (h[1]) return 2'b11;
      else if (r[0]) return 2'b10;
      else if (r[1]) return 2'b11;
      return 2'b00;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all(input logic [7:0] m);
      check("R2/R3 register", sfr_rd_data, m);
      check("R7 irq_req", {6'd0, irq_req}, {6'd0, exp_req(m)});
      check("R8 irq_hi", {6'd0, irq_hi}, {6'd0, m[7], m[3]});
      check("R9 select", {6'd0, sel_valid, sel_src}, {6'd0, exp_sel(m)});
   endtask

   task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
      sfr_wr_en = 1'b1; sfr_wr_addr = a; sfr_wr_data = d;
      @(negedge clk);
      sfr_wr_en = 1'b0;
   endtask

   task automatic wr_bit(input logic [7:0] a, input logic v);
      bit_wr_en = 1'b1; bit_wr_addr = a; bit_wr_val = v;
      @(negedge clk);
      bit_wr_en = 1'b0;
   endtask

   task automatic do_ack(input logic s);
      ack_valid = 1'b1; ack_src = s;
      @(negedge clk);
      ack_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] m;
      void'($urandom(32'd2024));
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1: reset state
      check("R1 reset value", sfr_rd_data, 8'h00);
      check("R1 outputs", {5'd0, irq_req, sel_valid}, 8'h00);
      sfr_rd_addr = 8'hC1;
      check("R1 other address reads 0", sfr_rd_data, 8'h00);
      sfr_rd_addr = 8'hC0;
      // R2: byte write to another address ignored
      wr_byte(8'hC8, 8'hFF);
      check("R2 stray byte write ignored", sfr_rd_data, 8'h00);

      // Random patterns, edge mode on both sources so flags hold software values
      for (int i = 0; i < 60; i++) begin
         logic [7:0] d;
         int k;
         logic v;
         d = 8'($urandom) | 8'h11;
         wr_byte(8'hC0, d);
         wr_byte(8'hC0, d);
         m = d;
         check_all(m);  // R11 software set/clear via byte write
         k = int'($urandom % 8);
         v = 1'($urandom);
         wr_bit(8'hC0 + 8'(k), v);
         m[k] = v;
         idle(1);
         if (!m[0]) m[1] = 1'b0;
         if (!m[4]) m[5] = 1'b0;
         check_all(m);  // R3 single-bit update
      end

      // Directed: R9 ordering
      wr_byte(8'hC0, 8'h77);
      check("R9 same level INT2 first", {6'd0, sel_valid, sel_src}, 8'h02);
      wr_byte(8'hC0, 8'hF7);
      check("R9 high level INT3 wins", {6'd0, sel_valid, sel_src}, 8'h03);

      // R4: edge detection latency, edge mode, disabled
      wr_byte(8'hC0, 8'h11);
      int_pin_n[0] = 1'b0;
      idle(2);
      check("R4 flag not yet set", sfr_rd_data, 8'h11);
      idle(1);
      check("R4 flag set on third edge", sfr_rd_data, 8'h13);
      // R5: ack clears it
      do_ack(1'b0);
      check("R5 ack clears INT2 flag", sfr_rd_data, 8'h11);
      idle(5);
      check("R4 held low does not retrigger", sfr_rd_data, 8'h11);
      int_pin_n[0] = 1'b1;
      idle(4);
      // R5: wrong-source ack
      int_pin_n[1] = 1'b0;
      idle(4);
      check("R4 INT3 edge sets flag", sfr_rd_data, 8'h31);
      do_ack(1'b0);
      check("R5 other ack leaves INT3", sfr_rd_data, 8'h31);
      do_ack(1'b1);
      check("R5 own ack clears INT3", sfr_rd_data, 8'h11);
      int_pin_n[1] = 1'b1;
      idle(4);

      // R6: level mode
      wr_byte(8'hC0, 8'h00);
      int_pin_n[0] = 1'b0;
      idle(4);
      check("R6 level flag follows pin", sfr_rd_data, 8'h02);
      do_ack(1'b0);
      check("R6 ack no effect in level", sfr_rd_data, 8'h02);
      int_pin_n[0] = 1'b1;
      idle(4);
      check("R6 level flag drops", sfr_rd_data, 8'h00);

      // R10: hardware set beats software clear
      wr_byte(8'hC0, 8'h11);
      int_pin_n[0] = 1'b0;
      idle(2);
      wr_bit(8'hC1, 1'b0);
      check("R10 hardware set wins", sfr_rd_data, 8'h13);
      wr_bit(8'hC1, 1'b0);
      check("R11 software clear", sfr_rd_data, 8'h11);
      wr_bit(8'hC5, 1'b1);
      check("R11 software set", sfr_rd_data, 8'h31);
      int_pin_n[0] = 1'b1;
      idle(2);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule